// File: doc/BRIEF.md
# Dual-Mode System Tick Timer

This block is a system tick source with a counter whose width is set by a parameter (32 bits by default). Software reaches it over a small register port that takes byte writes and returns byte reads. The timer has two modes. In interval mode the counter is loaded from a compare register and counts down. At zero it pulses the interrupt line and reloads, so the tick period is compare + 1 clocks. In free-running comparison mode the counter starts from zero and counts up, wrapping at its top value. It pulses the interrupt line in every cycle in which the count equals the compare register.

Counting is never controlled through a plain enable bit. Software writes a one-shot start trigger or a one-shot stop trigger, and reads a status bit to see whether the counter is running. A start written while the counter already runs means different things in the two modes. In interval mode it forces a reload and a fresh period. In free-running mode it is ignored. The mode bit and the compare value are frozen while the counter runs.

Top module: `tick_timer`

## Requirements
- R1: After reset the status, the mode, the compare value and the count are all zero, and the interrupt output is low.
- R2: The start trigger (offset 0x14) and the stop trigger (offset 0x18) always read 0x00. Only bit 0 of a write to them acts. A written byte whose bit 0 is 0 changes nothing.
- R3: Writing a byte with bit 0 set to offset 0x14 sets the running flag, which reads as bit 0 of the status register at offset 0x10, on the next clock.
- R4: Writing a byte with bit 0 set to offset 0x18 clears the running flag. The count holds the value it had when the stop was written.
- R5: In interval mode (mode bit 0) a start loads the count with the compare value. While running, the count drops by one per clock. In a cycle where the count is zero, the interrupt is high and the next count is the compare value.
- R6: In interval mode a start written while running reloads the count from the compare value.
- R7: In free-running mode (mode bit 1) a start from the stopped state clears the count to zero. The count then rises by one per clock and wraps from all ones to zero.
- R8: In free-running mode a start written while running is ignored. The running flag stays set and the count keeps rising without a break.
- R9: In free-running mode the interrupt is high in exactly the running cycles where the count equals the compare value.
- R10: The compare value (bytes at offsets 0x00 to 0x03, least significant byte first) and the mode bit (bit 0 at offset 0x1C) take writes only while the timer is stopped. Writes made while it runs are ignored.
- R11: While stopped, the count holds its value and reads back at offsets 0x04 to 0x07, least significant byte first, and the interrupt stays low.
- R12: Every offset not listed above, and every byte lane beyond the counter width, reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset for both reads and writes |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte for bus_addr, combinational |
| tick_irq | output | 1 | Interrupt, high for each tick cycle |

## Verification
A wrong running flag shows up on the status byte one clock after the offending trigger. Because it also gates counting, the count read-back drifts away from the model in the following cycle. A wrong reload or step shows up as a wrong count byte on the very next clock, and it moves the interrupt pulse by one or more cycles. A compare or mode write that leaks through while running changes the read-back of that register at once, and changes the tick timing later. The bench therefore compares the read byte and the interrupt against its model on every cycle, so no fault stays hidden beyond the cycle after its cause.

// File: rtl/tick_pkg.sv
package tick_pkg;
   typedef enum logic {
      TM_INTERVAL = 1'b0,
      TM_FREERUN  = 1'b1
   } tick_mode_e;

   localparam int unsigned OFF_CMP   = 32'h00;
   localparam int unsigned OFF_CNT   = 32'h04;
   localparam int unsigned OFF_STAT  = 32'h10;
   localparam int unsigned OFF_START = 32'h14;
   localparam int unsigned OFF_STOP  = 32'h18;
   localparam int unsigned OFF_MODE  = 32'h1C;
   localparam int unsigned MAX_LANES = 4;
endpackage

// File: rtl/tick_regs.sv
module tick_regs
   import tick_pkg::*;
#(
   parameter int COUNT_W = 32,
   parameter int ADDR_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_we,
   input  logic [7:0]         bus_wdata,
   input  logic               running,
   input  logic [COUNT_W-1:0] count,
   output logic               start_hit,
   output logic               stop_hit,
   output tick_mode_e         mode,
   output logic [COUNT_W-1:0] cmp,
   output logic [7:0]         bus_rdata
);
   localparam int NB = COUNT_W / 8;
   localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);
   localparam logic [ADDR_W-1:0] A_START = ADDR_W'(OFF_START);
   localparam logic [ADDR_W-1:0] A_STOP  = ADDR_W'(OFF_STOP);
   localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFF_MODE);

   generate
      if (COUNT_W % 8 != 0 || COUNT_W < 8 || NB > MAX_LANES)
         $error("tick_regs: COUNT_W must be 8, 16, 24 or 32");
      if (ADDR_W < 5)
         $error("tick_regs: ADDR_W must be at least 5");
   endgenerate

   logic cfg_open;
   assign cfg_open  = bus_we & ~running;
   assign start_hit = bus_we & (bus_addr == A_START) & bus_wdata[0];
   assign stop_hit  = bus_we & (bus_addr == A_STOP)  & bus_wdata[0];

   genvar g;
   generate
      for (g = 0; g < NB; g++) begin : g_cmp_lane
         localparam logic [ADDR_W-1:0] A_LANE = ADDR_W'(OFF_CMP + g);
         always_ff @(posedge clk) begin
            if (!rst_n)
               cmp[8*g +: 8] <= 8'h00;
            else if (cfg_open && bus_addr == A_LANE)
               cmp[8*g +: 8] <= bus_wdata;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         mode <= TM_INTERVAL;
      else if (cfg_open && bus_addr == A_MODE)
         mode <= tick_mode_e'(bus_wdata[0]);
   end

   always_comb begin
      bus_rdata = 8'h00;
      for (int i = 0; i < NB; i++) begin
         if (bus_addr == ADDR_W'(OFF_CMP + i)) bus_rdata = cmp[8*i +: 8];
         if (bus_addr == ADDR_W'(OFF_CNT + i)) bus_rdata = count[8*i +: 8];
      end
      if (bus_addr == A_STAT) bus_rdata = {7'b0, running};
      if (bus_addr == A_MODE) bus_rdata = {7'b0, mode};
   end

   // R10: configuration is frozen while counting
   a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      running |=> ($stable(cmp) && $stable(mode)));
endmodule

// File: rtl/tick_ctrl.sv
module tick_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic start_hit,
   input  logic stop_hit,
   output logic running
);
   always_ff @(posedge clk) begin
      if (!rst_n)        running <= 1'b0;
      else if (stop_hit) running <= 1'b0;
      else if (start_hit) running <= 1'b1;
   end

   a_r3_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
      (start_hit && !stop_hit) |=> running);
   a_r4_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
      stop_hit |=> !running);
endmodule

// File: rtl/tick_counter.sv
module tick_counter
   import tick_pkg::*;
#(
   parameter int COUNT_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               running,
   input  logic               start_hit,
   input  logic               stop_hit,
   input  tick_mode_e         mode,
   input  logic [COUNT_W-1:0] cmp,
   output logic [COUNT_W-1:0] count,
   output logic               irq
);
   generate
      if (COUNT_W < 2) $error("tick_counter: COUNT_W too small");
   endgenerate

   logic load_now;
   logic at_zero;
   assign load_now = start_hit & ((mode == TM_INTERVAL) | ~running);
   assign at_zero  = (count == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)
         count <= '0;
      else if (stop_hit)
         count <= count;
      else if (load_now)
         count <= (mode == TM_INTERVAL) ? cmp : '0;
      else if (running) begin
         if (mode == TM_INTERVAL)
            count <= at_zero ? cmp : count - 1'b1;
         else
            count <= count + 1'b1;
      end
   end

   assign irq = running & ((mode == TM_INTERVAL) ? at_zero : (count == cmp));

   a_r4_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
      stop_hit |=> count == $past(count));
   a_r5_reload_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (running && mode == TM_INTERVAL && at_zero && !start_hit && !stop_hit)
      |=> count == $past(cmp));
   a_r6_forced_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (running && mode == TM_INTERVAL && start_hit && !stop_hit)
      |=> count == $past(cmp));
   a_r8_free_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (running && mode == TM_FREERUN && start_hit && !stop_hit)
      |=> (running && count == COUNT_W'($past(count) + 1'b1)));
   a_r11_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !start_hit) |=> count == $past(count));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_pkg::*;
#(
   parameter int COUNT_W = 32,
   parameter int ADDR_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              tick_irq
);
   logic               start_hit;
   logic               stop_hit;
   logic               running;
   tick_mode_e         mode;
   logic [COUNT_W-1:0] cmp;
   logic [COUNT_W-1:0] count;

   tick_regs #(.COUNT_W(COUNT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .running(running), .count(count),
      .start_hit(start_hit), .stop_hit(stop_hit), .mode(mode), .cmp(cmp),
      .bus_rdata(bus_rdata)
   );

   tick_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .start_hit(start_hit), .stop_hit(stop_hit),
      .running(running)
   );

   tick_counter #(.COUNT_W(COUNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .running(running), .start_hit(start_hit),
      .stop_hit(stop_hit), .mode(mode), .cmp(cmp), .count(count),
      .irq(tick_irq)
   );

   // R9: free-running tick exactly on a compare match while running
   a_r9_free_match: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TM_FREERUN && tick_irq) |-> (running && count == cmp));
   // R11: no ticks while stopped
   a_r11_quiet_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(running) |-> !tick_irq);
endmodule

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
   localparam int TB_W = 16;
   localparam int NB   = TB_W / 8;
   localparam int unsigned MASK = (1 << TB_W) - 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       tick_irq;

   always #5 clk = ~clk;

   tick_timer #(.COUNT_W(TB_W), .ADDR_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_irq(tick_irq)
   );

   // behavioural reference
   bit          m_run, m_mode;
   int unsigned m_cmp, m_cnt;
   int          vectors = 0, miscompares = 0;
   bit          done = 0;
   string       cur_req = "R1";

   always @(posedge clk) begin
      bit st, sp;
      if (!rst_n) begin
         m_run <= 0; m_mode <= 0; m_cmp <= 0; m_cnt <= 0;
      end else begin
         st = bus_we && bus_addr == 8'h14 && bus_wdata[0];
         sp = bus_we && bus_addr == 8'h18 && bus_wdata[0];
         if (sp) m_run <= 0;
         else if (st && (m_mode == 0 || !m_run)) begin
            m_run <= 1;
            m_cnt <= (m_mode == 0) ? m_cmp : 0;
         end else if (m_run) begin
            if (m_mode == 0) m_cnt <= (m_cnt == 0) ? m_cmp : m_cnt - 1;
            else             m_cnt <= (m_cnt + 1) & MASK;
         end
         if (bus_we && !m_run) begin
            for (int i = 0; i < NB; i++)
               if (bus_addr == 8'(i))
                  m_cmp <= (m_cmp & ~(32'hFF << (8*i))) | (int'(bus_wdata) << (8*i));
            if (bus_addr == 8'h1C) m_mode <= bus_wdata[0];
         end
      end
   end

   function automatic logic [7:0] exp_rd(logic [7:0] a);
      logic [7:0] r = 8'h00;
      for (int i = 0; i < NB; i++) begin
         if (a == 8'(i))     r = 8'(m_cmp >> (8*i));
         if (a == 8'(4 + i)) r = 8'(m_cnt >> (8*i));
      end
      if (a == 8'h10) r = {7'b0, m_run};
      if (a == 8'h1C) r = {7'b0, m_mode};
      return r;
   endfunction

   always @(posedge clk) begin
      logic [7:0] er;
      logic       ei;
      #2;
      if (rst_n && !done) begin
         er = exp_rd(bus_addr);
         ei = m_run && ((m_mode == 0) ? (m_cnt == 0) : (m_cnt == m_cmp));
         vectors++;
         if (bus_rdata !== er || tick_irq !== ei) begin
            miscompares++;
            $display("FAIL %s addr=%h rdata=%h expected %h irq=%b expected %b",
                     cur_req, bus_addr, bus_rdata, er, tick_irq, ei);
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic watch(input logic [7:0] a, input int n);
      bus_addr = a;
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset values of every register
      cur_req = "R1";
      for (int a = 0; a < 8; a++) watch(8'(a), 1);
      watch(8'h10, 1); watch(8'h1C, 1);
      // R2: triggers read zero, bit-0-clear writes inert
      cur_req = "R2";
      watch(8'h14, 1); watch(8'h18, 1);
      wr(8'h14, 8'hFE); watch(8'h10, 2);
      wr(8'h18, 8'h00); watch(8'h10, 2);
      // R12: unmapped offsets and absent lanes
      cur_req = "R12";
      watch(8'h02, 1); watch(8'h07, 1); watch(8'h09, 1); watch(8'hFF, 1);
      // R5: interval countdown with period cmp+1
      cur_req = "R5";
      wr(8'h00, 8'h03); wr(8'h1C, 8'h00);
      cur_req = "R3";
      wr(8'h14, 8'h01); watch(8'h10, 2);
      cur_req = "R5";
      watch(8'h04, 14);
      // R6: forced restart in interval mode
      cur_req = "R6";
      wr(8'h14, 8'hFF); watch(8'h04, 6);
      // R10: configuration frozen while running
      cur_req = "R10";
      wr(8'h00, 8'h20); watch(8'h00, 2);
      wr(8'h1C, 8'h01); watch(8'h1C, 2);
      // R4 / R11: stop, hold, no ticks
      cur_req = "R4";
      wr(8'h18, 8'h01); watch(8'h10, 1);
      cur_req = "R11";
      watch(8'h04, 8);
      // R7 / R9: free-running from zero, tick on match
      cur_req = "R7";
      wr(8'h1C, 8'h01); wr(8'h00, 8'h10); wr(8'h01, 8'h00);
      wr(8'h14, 8'h01); watch(8'h04, 6);
      cur_req = "R9";
      watch(8'h04, 20);
      // R8: start while running is ignored
      cur_req = "R8";
      wr(8'h14, 8'h01); watch(8'h04, 4); watch(8'h10, 2);
      // R7: wrap of the count through all ones
      cur_req = "R7";
      watch(8'h05, 65600);
      cur_req = "R11";
      wr(8'h18, 8'h01); watch(8'h05, 3); watch(8'h04, 3);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         miscompares++;
         $display("FAIL watchdog %s: run did not end, actual hung expected finished", cur_req);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule